// File: doc/BRIEF.md
# Teletext Serial Data Inserter

This block places teletext bits into the luma data path of a 625-line video encoder. On each line that is enabled it raises a request strobe. An external source answers the strobe with one serial bit per strobe clock, driven on rising clock edges. The sampled bit is held on a one-bit insertion output, with a valid flag, until the next bit boundary. A later pulse-shaping stage turns this output into the luma waveform.

The teletext rate is 444 bits per line. A line lasts 1728 system clocks, so the bit period is not a whole number of clocks. A phase accumulator adds a fixed step each clock and wraps at a fixed modulus. Every wrap marks a bit boundary, which makes each bit last 3 or 4 clocks. Starting at a fixed clock offset into the line, a set number of bits is taken. The strobe can be moved earlier by a whole number of clocks to cover latency in the source. The clocks in which bits are sampled do not move. A test mode drives an alternating 1/0 pattern in place of the serial input.

Each line is gated by four things: a 625-line format flag, a global enable, and one enable bit per line number in each of two masks, one for odd fields and one for even fields. All per-line settings are captured at the line-start pulse.

Top module: `ttx_inserter`

## Requirements
- R1: The request and the valid flag stay low on a line unless `fmt_625`, `ttx_en` and the selected mask bit were all 1 at that line's start. Line numbers at or above LINES are never enabled.
- R2: The selected mask bit is `odd_mask[line_num]` when `field_odd` is 1 and `even_mask[line_num]` when `field_odd` is 0.
- R3: Let k be the number of clocks since the edge that sampled `line_start` (k=0 is the first clock after it). A bit boundary falls at k when ((k*STEP) mod MODULUS) + STEP >= MODULUS. With `req_adv`=0, `ttx_req` is high at k exactly when the line is enabled, k >= START, k is a boundary, and fewer than BITS earlier boundaries at or after START exist.
- R4: An enabled line gives exactly BITS request clocks. The defaults of 111/432 per clock give 444 boundaries per 1728-clock line.
- R5: Two consecutive request clocks on a line are floor(MODULUS/STEP) or ceil(MODULUS/STEP) clocks apart, which is 3 or 4 for both the default and the small configuration.
- R6: With `req_adv`=a, `ttx_req` at k equals the R3 request at k+a. Bits are still sampled at the R3 clocks.
- R7: The value of `ttx_data` at a sampling clock k appears on `ins_bit` from k+1 and is held until the next sampling clock. After a line start `ins_bit` is 0 until the first sample.
- R8: `ins_valid` rises in the clock after the first sample of a line and falls in the clock after the first bit boundary that has no sample, that is, after the last bit.
- R9: While `test_pat` is 1, the sampled value is 1 for a line's first bit and then alternates 1,0,1,... at each later sample, and `ttx_data` is ignored.
- R10: While reset is low and after it is released, `ttx_req`, `ins_bit` and `ins_valid` are 0 until an enabled line starts.
- R11: Changes to `fmt_625`, `ttx_en`, `field_odd`, `line_num`, the masks or `req_adv` after a line start do not affect that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (27 MHz nominal) |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| line_start | input | 1 | One-clock pulse that starts a line |
| line_num | input | LINE_NUM_W | Line number within the field, sampled at line start |
| field_odd | input | 1 | 1 for odd field, 0 for even field |
| fmt_625 | input | 1 | Output format is a 625-line variant |
| ttx_en | input | 1 | Global teletext enable |
| test_pat | input | 1 | Replace serial input with alternating pattern |
| req_adv | input | ADV_W | Request advance in clocks |
| odd_mask | input | LINES | Per-line enable, odd field |
| even_mask | input | LINES | Per-line enable, even field |
| ttx_data | input | 1 | Serial teletext data from source |
| ttx_req | output | 1 | Data request strobe |
| ins_bit | output | 1 | Bit for insertion into luma |
| ins_valid | output | 1 | ins_bit carries a teletext bit |

## Verification
The enable gate is swept over every combination of format, global enable, field and line number, including line numbers outside the mask. Masks that differ between fields show whether the right mask and bit are selected. Every advance value is run with data patterns that change from line to line. Comparing the request position with the fixed sample position shows whether the strobe shifts while sampling stays put, and the varying data catches sampling on the wrong clock. Test-pattern lines with noisy input data show that the input is ignored. Lines whose settings change a few clocks after the start show that the settings are captured only at line start.

// File: rtl/ttx_pkg.sv
`timescale 1ns/1ps
package ttx_pkg;
    // One clock of the bit engine: a bit boundary, and whether a bit is taken there
    typedef struct packed {
        logic req;
        logic tick;
    } ttx_evt_t;
endpackage

// File: rtl/ttx_line_gate.sv
`timescale 1ns/1ps
module ttx_line_gate #(
    parameter int LINES      = 24,
    parameter int LINE_NUM_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start,
    input  logic [LINE_NUM_W-1:0] line_num,
    input  logic                  field_odd,
    input  logic                  fmt_625,
    input  logic                  ttx_en,
    input  logic [LINES-1:0]      odd_mask,
    input  logic [LINES-1:0]      even_mask,
    output logic                  line_en
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic line_en_d, line_en_q;
    logic [LINES-1:0] sel_mask;
    logic             in_range;

    always_comb begin
        sel_mask  = field_odd ? odd_mask : even_mask;
        in_range  = (int'(line_num) < LINES);
        line_en_d = line_en_q;
        if (line_start) begin
            line_en_d = fmt_625 & ttx_en & in_range & sel_mask[line_num[IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_en_q <= 1'b0;
        else        line_en_q <= line_en_d;
    end

    assign line_en = line_en_q;

    AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(line_en_q)); // R11
endmodule

// File: rtl/ttx_bit_clock.sv
`timescale 1ns/1ps
module ttx_bit_clock
    import ttx_pkg::*;
#(
    parameter int LINE_CLKS = 1728,
    parameter int STEP      = 111,
    parameter int MODULUS   = 432,
    parameter int BITS      = 360,
    parameter int START     = 240,
    parameter int ADV_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             line_en,
    input  logic [ADV_W-1:0] req_adv,
    output ttx_evt_t         evt,
    output logic [ADV_W-1:0] adv_held
);
    localparam int POS_MAX = LINE_CLKS + (1 << ADV_W);
    localparam int POS_W   = $clog2(POS_MAX + 1);
    localparam int ACC_W   = $clog2(MODULUS);
    localparam int SUM_W   = ACC_W + 1;
    localparam int CNT_W   = $clog2(BITS + 1);
    localparam logic [POS_W-1:0] POS_TOP   = POS_W'(POS_MAX);
    localparam logic [POS_W-1:0] POS_START = POS_W'(START);
    localparam logic [SUM_W-1:0] STEP_S    = SUM_W'(STEP);
    localparam logic [SUM_W-1:0] MOD_S     = SUM_W'(MODULUS);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(BITS);

    // The engine runs req_adv clocks ahead of the sampling clocks
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [ADV_W-1:0] adv;
    } clk_state_t;

    clk_state_t st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic             tick, req;
    logic [31:0]      acc_init;

    always_comb begin
        st_d     = st_q;
        sum      = {1'b0, st_q.acc} + STEP_S;
        tick     = (sum >= MOD_S);
        req      = line_en & (st_q.pos >= POS_START) & tick & (st_q.cnt < CNT_TOP);
        acc_init = (32'(req_adv) * 32'(STEP)) % 32'(MODULUS);

        st_d.acc = tick ? ACC_W'(sum - MOD_S) : ACC_W'(sum);
        st_d.pos = (st_q.pos == POS_TOP) ? st_q.pos : st_q.pos + 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(req);
        if (line_start) begin
            st_d.pos = POS_W'(req_adv);
            st_d.acc = ACC_W'(acc_init);
            st_d.cnt = '0;
            st_d.adv = req_adv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt.req  = req;
    assign evt.tick = tick;
    assign adv_held = st_q.adv;

    AST_REQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        evt.req |-> line_en); // R1
endmodule

// File: rtl/ttx_take_stage.sv
`timescale 1ns/1ps
module ttx_take_stage
    import ttx_pkg::*;
#(
    parameter int STEP    = 111,
    parameter int MODULUS = 432,
    parameter int ADV_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  ttx_evt_t         evt,
    input  logic [ADV_W-1:0] adv_held,
    input  logic             test_pat,
    input  logic             ttx_data,
    output logic             ins_bit,
    output logic             ins_valid
);
    localparam int DEPTH   = 1 << ADV_W;
    localparam int MIN_GAP = MODULUS / STEP;
    localparam int MAX_GAP = (MODULUS + STEP - 1) / STEP;

    typedef struct packed {
        ttx_evt_t [DEPTH-1:0] hist;
        logic                 dat;
        logic                 valid;
        logic                 pat;
    } take_state_t;

    take_state_t st_d, st_q;
    ttx_evt_t    dly;
    logic        take;

    always_comb begin
        st_d = st_q;
        dly  = (adv_held == '0) ? evt : st_q.hist[adv_held - 1'b1];
        take = dly.req;
        st_d.hist = {st_q.hist[DEPTH-2:0], evt};
        if (line_start) begin
            st_d.hist  = '0;
            st_d.dat   = 1'b0;
            st_d.valid = 1'b0;
            st_d.pat   = 1'b0;
        end else if (take) begin
            st_d.dat   = test_pat ? ~st_q.pat : ttx_data;
            st_d.pat   = ~st_q.pat;
            st_d.valid = 1'b1;
        end else if (dly.tick) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ins_bit   = st_q.dat;
    assign ins_valid = st_q.valid;

    // Spacing and pattern trackers used by the assertions only
    logic [7:0] gap_q;
    logic       last_test_q;
    always_ff @(posedge clk) begin
        if (!rst_n || line_start) begin
            gap_q       <= '0;
            last_test_q <= 1'b0;
        end else if (take) begin
            gap_q       <= 8'd1;
            last_test_q <= test_pat;
        end else if (gap_q != '0 && gap_q != 8'hFF) begin
            gap_q       <= gap_q + 1'b1;
        end
    end

    AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !line_start && gap_q != '0) |->
            (int'(gap_q) >= MIN_GAP && int'(gap_q) <= MAX_GAP)); // R5
    AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !line_start) |=> ins_valid); // R8
    AST_PATTERN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !line_start && test_pat && last_test_q) |=> (ins_bit != $past(ins_bit))); // R9
endmodule

// File: rtl/ttx_inserter.sv
`timescale 1ns/1ps
module ttx_inserter
    import ttx_pkg::*;
#(
    parameter int LINE_CLKS  = 1728,
    parameter int STEP       = 111,
    parameter int MODULUS    = 432,
    parameter int BITS       = 360,
    parameter int START      = 240,
    parameter int ADV_W      = 4,
    parameter int LINES      = 24,
    parameter int LINE_NUM_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start,
    input  logic [LINE_NUM_W-1:0] line_num,
    input  logic                  field_odd,
    input  logic                  fmt_625,
    input  logic                  ttx_en,
    input  logic                  test_pat,
    input  logic [ADV_W-1:0]      req_adv,
    input  logic [LINES-1:0]      odd_mask,
    input  logic [LINES-1:0]      even_mask,
    input  logic                  ttx_data,
    output logic                  ttx_req,
    output logic                  ins_bit,
    output logic                  ins_valid
);
    logic             line_en;
    ttx_evt_t         evt;
    logic [ADV_W-1:0] adv_held;

    ttx_line_gate #(.LINES(LINES), .LINE_NUM_W(LINE_NUM_W)) gate_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .line_num(line_num), .field_odd(field_odd), .fmt_625(fmt_625),
        .ttx_en(ttx_en), .odd_mask(odd_mask), .even_mask(even_mask),
        .line_en(line_en)
    );

    ttx_bit_clock #(.LINE_CLKS(LINE_CLKS), .STEP(STEP), .MODULUS(MODULUS),
                    .BITS(BITS), .START(START), .ADV_W(ADV_W)) clock_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_en(line_en),
        .req_adv(req_adv), .evt(evt), .adv_held(adv_held)
    );

    ttx_take_stage #(.STEP(STEP), .MODULUS(MODULUS), .ADV_W(ADV_W)) take_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .evt(evt),
        .adv_held(adv_held), .test_pat(test_pat), .ttx_data(ttx_data),
        .ins_bit(ins_bit), .ins_valid(ins_valid)
    );

    assign ttx_req = evt.req;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_en && !line_start) |=> !ttx_req); // R1
endmodule

// File: tb/ttx_inserter_tb.sv
`timescale 1ns/1ps
module ttx_inserter_tb_top;
    localparam int LC = 64, S = 5, M = 18, NB = 8, ST = 12, AW = 3, NL = 4, LW = 3;

    logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0;
    logic [LW-1:0] line_num = '0;
    logic field_odd = 1'b0, fmt_625 = 1'b0, ttx_en = 1'b0, test_pat = 1'b0, ttx_data = 1'b0;
    logic [AW-1:0] req_adv = '0;
    logic [NL-1:0] odd_mask = 4'b0110, even_mask = 4'b1001;
    logic ttx_req, ins_bit, ins_valid;

    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    ttx_inserter #(.LINE_CLKS(LC), .STEP(S), .MODULUS(M), .BITS(NB), .START(ST),
                   .ADV_W(AW), .LINES(NL), .LINE_NUM_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
        .field_odd(field_odd), .fmt_625(fmt_625), .ttx_en(ttx_en), .test_pat(test_pat),
        .req_adv(req_adv), .odd_mask(odd_mask), .even_mask(even_mask),
        .ttx_data(ttx_data), .ttx_req(ttx_req), .ins_bit(ins_bit), .ins_valid(ins_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_tick(input int q);
        return ((q * S) % M) + S >= M;
    endfunction

    function automatic bit data_at(input int k, input int seed);
        return 1'(((k * 13 + seed) ^ (k >> 2) ^ seed * 7) & 1);
    endfunction

    // Runs one line from a negedge; ends at the negedge of its last clock
    task automatic run_line(input bit fmt, input bit en, input bit fld, input int ln,
                            input int adv, input bit tst, input int seed, input bit mutate);
        bit take_arr [0:127];
        bit en_exp, v_exp, b_exp, pat;
        int cnt, nreq, last_req;
        string rtag;
        en_exp = fmt && en && ln < NL && (fld ? odd_mask[ln] : even_mask[ln]); // R1 R2
        cnt = 0;
        for (int q = 0; q < 128; q++) begin
            take_arr[q] = en_exp && q >= ST && is_tick(q) && cnt < NB;
            if (take_arr[q]) cnt++;
        end
        fmt_625 = fmt; ttx_en = en; field_odd = fld; line_num = LW'(ln);
        req_adv = AW'(adv); test_pat = tst; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        v_exp = 0; b_exp = 0; pat = 0; nreq = 0; last_req = -1;
        rtag = !en_exp ? (fmt && en ? "R2" : "R1") : (mutate ? "R11" : (adv != 0 ? "R6" : "R3"));
        for (int k = 0; k < LC - 1; k++) begin
            ttx_data = data_at(k, seed);
            if (mutate && k == 5) begin
                fmt_625 = ~fmt; ttx_en = ~en; field_odd = ~fld;
                line_num = LW'(ln + 1); req_adv = AW'(adv + 3);
                odd_mask = ~odd_mask; even_mask = ~even_mask;
            end
            chk(ttx_req == take_arr[k + adv], rtag, int'(ttx_req), int'(take_arr[k + adv]));
            chk(ins_valid == v_exp, mutate ? "R11" : "R8", int'(ins_valid), int'(v_exp));
            chk(ins_bit == b_exp, tst ? "R9" : "R7", int'(ins_bit), int'(b_exp));
            if (ttx_req) begin
                if (last_req >= 0)
                    chk(k - last_req >= M / S && k - last_req <= (M + S - 1) / S, "R5",
                        k - last_req, M / S);
                last_req = k;
                nreq++;
            end
            if (take_arr[k]) begin
                b_exp = tst ? ~pat : ttx_data;
                pat = ~pat;
                v_exp = 1;
            end else if (is_tick(k)) begin
                v_exp = 0;
            end
            @(negedge clk);
        end
        chk(nreq == (en_exp ? NB : 0), "R4", nreq, en_exp ? NB : 0);
        if (mutate) begin
            odd_mask = ~odd_mask; even_mask = ~even_mask;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in and after reset
        chk(!ttx_req && !ins_bit && !ins_valid, "R10", int'({ttx_req, ins_bit, ins_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ttx_req && !ins_bit && !ins_valid, "R10", int'({ttx_req, ins_bit, ins_valid}), 0);
        // R1 R2: full sweep of the enable gate
        for (int f = 0; f < 2; f++)
            for (int e = 0; e < 2; e++)
                for (int fl = 0; fl < 2; fl++)
                    for (int ln = 0; ln < 6; ln++)
                        run_line(f[0], e[0], fl[0], ln, 0, 1'b0, ln * 3 + fl, 1'b0);
        // R3 R6 R7: every advance value, varying data
        for (int a = 0; a < (1 << AW); a++)
            run_line(1'b1, 1'b1, 1'b1, 1, a, 1'b0, a * 5 + 1, 1'b0);
        // R9: test pattern ignores data
        run_line(1'b1, 1'b1, 1'b0, 0, 0, 1'b1, 9, 1'b0);
        run_line(1'b1, 1'b1, 1'b0, 3, 4, 1'b1, 2, 1'b0);
        // R11: settings changed after line start
        run_line(1'b1, 1'b1, 1'b1, 2, 2, 1'b0, 4, 1'b1);
        run_line(1'b1, 1'b1, 1'b0, 3, 0, 1'b0, 6, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule